// File: doc/BRIEF.md
# Interrupt Enable Register with NMI-Gated Masking

This block is the CPU control register that holds one enable bit per maskable interrupt line (lines 15 down to 4), a sticky enable for the nonmaskable interrupt, and a reset-interrupt enable that is always on. It also contains the combinational qualification logic. Each pending interrupt is ANDed with its enable, with the NMI enable, and with the global enable taken from the status register. The result tells the downstream prioritiser which requests may start interrupt processing.

Software reaches the register through a control-register move port. A write lands on the clock edge that samples the strobe, and a read returns the current contents combinationally. The NMI enable behaves differently from the line enables. Software may set it but can never clear it. Taking an NMI clears it, and completing the return-from-NMI branch sets it again. While it is clear, every interrupt except reset is held off.

Top module: `irq_enable_reg`

## Requirements
- R1: After reset the read value is 32'h0000_0001: all line enables are 0, the NMI enable (bit 1) is 0 and bit 0 reads 1.
- R2: Bits 31..16 and bits 3..2 always read 0, and writing 1 to them changes no output.
- R3: A write with `wr_en`=1 loads `wr_data[15:4]` into the line enables, read back at bits 15..4. Without a write those bits hold.
- R4: A write with bit 1 = 1 sets the NMI enable. A write with bit 1 = 0 leaves it unchanged.
- R5: `nmi_taken`=1 clears the NMI enable at the next edge. This takes priority over a same-cycle software set and over `nmi_return`.
- R6: `nmi_return`=1 without `nmi_taken` sets the NMI enable at the next edge.
- R7: Bit 0 reads 1 whatever is written, and `qual_rst` equals `pend_rst` at all times.
- R8: `qual_nmi` = `pend_nmi` AND NMI enable.
- R9: `qual_lines[i]` (line i+4) = `pend_lines[i]` AND line enable i AND `gie` AND NMI enable.
- R10: A write is not visible on `rd_data` before the clock edge that samples it, and it is visible right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe from the move instruction |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Current register value |
| nmi_taken | input | 1 | NMI accepted this cycle (clears NMI enable) |
| nmi_return | input | 1 | Return-from-NMI branch completed (sets NMI enable) |
| gie | input | 1 | Global interrupt enable from the status register |
| pend_lines | input | 12 | Pending maskable lines 15..4 (bit 0 = line 4) |
| pend_nmi | input | 1 | NMI pending |
| pend_rst | input | 1 | Reset interrupt pending |
| qual_lines | output | 12 | Qualified maskable lines 15..4 |
| qual_nmi | output | 1 | Qualified NMI |
| qual_rst | output | 1 | Qualified reset interrupt |

## Verification
All state in this block shows on `rd_data` in the cycle right after the edge that changed it. A line enable or NMI enable that is corrupt, stuck or updated one edge late therefore shows up as a read mismatch one cycle after the offending write or event. Wrong gating shows up on the qualified outputs in the same cycle that the pending inputs are presented. The priority case, where a clear and a set arrive in the same cycle, is checked by driving both and reading bit 1 on the following cycle.

// File: rtl/irq_en_pkg.sv
package irq_en_pkg;

    localparam int REG_W     = 32;
    localparam int LINE_LO   = 4;
    localparam int LINE_HI   = 15;
    localparam int NUM_LINES = LINE_HI - LINE_LO + 1;
    localparam int NMI_BIT   = 1;
    localparam int RST_BIT   = 0;

    typedef logic [REG_W-1:0]     word_t;
    typedef logic [NUM_LINES-1:0] line_vec_t;

    // events acting on the sticky NMI enable
    typedef struct packed {
        logic set;
        logic clr;
    } nmi_evt_t;

    // architectural state of the register
    typedef struct packed {
        line_vec_t lines;
        logic      nmi_en;
    } en_state_t;

    // qualifier outputs bundled together
    typedef struct packed {
        line_vec_t lines;
        logic      nmi;
        logic      rst;
    } qual_t;

    function automatic word_t compose_read(en_state_t s);
        word_t r;
        r = '0;
        r[LINE_HI:LINE_LO] = s.lines;
        r[NMI_BIT]         = s.nmi_en;
        r[RST_BIT]         = 1'b1;
        return r;
    endfunction

    function automatic line_vec_t extract_lines(word_t d);
        return d[LINE_HI:LINE_LO];
    endfunction

endpackage

// File: rtl/irq_line_bank.sv
module irq_line_bank
    import irq_en_pkg::*;
#(
    parameter int N = NUM_LINES
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [N-1:0] wr_lines,
    output logic [N-1:0] en_q
);
    for (genvar i = 0; i < N; i++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst)
                en_q[i] <= 1'b0;
            else if (wr_en)
                en_q[i] <= wr_lines[i];
        end
    end
endmodule

// File: rtl/irq_nmi_latch.sv
module irq_nmi_latch
    import irq_en_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  nmi_evt_t evt,
    output logic     nmi_en_q
);
    logic nmi_en_d;

    // clear dominates any set in the same cycle
    always_comb begin
        nmi_en_d = nmi_en_q;
        if (evt.set)
            nmi_en_d = 1'b1;
        if (evt.clr)
            nmi_en_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)
            nmi_en_q <= 1'b0;
        else
            nmi_en_q <= nmi_en_d;
    end
endmodule

// File: rtl/irq_qualify.sv
module irq_qualify
    import irq_en_pkg::*;
#(
    parameter int N = NUM_LINES
) (
    input  logic [N-1:0] en_lines,
    input  logic         nmi_en,
    input  logic         gie,
    input  logic [N-1:0] pend_lines,
    input  logic         pend_nmi,
    input  logic         pend_rst,
    output logic [N-1:0] q_lines,
    output logic         q_nmi,
    output logic         q_rst
);
    logic mask_open;

    assign mask_open = gie & nmi_en;

    for (genvar i = 0; i < N; i++) begin : g_q
        assign q_lines[i] = pend_lines[i] & en_lines[i] & mask_open;
    end

    assign q_nmi = pend_nmi & nmi_en;
    assign q_rst = pend_rst;
endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg
    import irq_en_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [REG_W-1:0]     wr_data,
    output logic [REG_W-1:0]     rd_data,
    input  logic                 nmi_taken,
    input  logic                 nmi_return,
    input  logic                 gie,
    input  logic [NUM_LINES-1:0] pend_lines,
    input  logic                 pend_nmi,
    input  logic                 pend_rst,
    output logic [NUM_LINES-1:0] qual_lines,
    output logic                 qual_nmi,
    output logic                 qual_rst
);
    en_state_t st;
    nmi_evt_t  evt;
    qual_t     q;

    assign evt.set = (wr_en & wr_data[NMI_BIT]) | nmi_return;
    assign evt.clr = nmi_taken;

    irq_line_bank #(.N(NUM_LINES)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_lines (extract_lines(wr_data)),
        .en_q     (st.lines)
    );

    irq_nmi_latch u_nmi (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .nmi_en_q (st.nmi_en)
    );

    irq_qualify #(.N(NUM_LINES)) u_qual (
        .en_lines   (st.lines),
        .nmi_en     (st.nmi_en),
        .gie        (gie),
        .pend_lines (pend_lines),
        .pend_nmi   (pend_nmi),
        .pend_rst   (pend_rst),
        .q_lines    (q.lines),
        .q_nmi      (q.nmi),
        .q_rst      (q.rst)
    );

    assign rd_data    = compose_read(st);
    assign qual_lines = q.lines;
    assign qual_nmi   = q.nmi;
    assign qual_rst   = q.rst;
endmodule

// File: rtl/irq_enable_reg_chk.sv
module irq_enable_reg_chk
    import irq_en_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 wr_en,
    input logic [REG_W-1:0]     wr_data,
    input logic [REG_W-1:0]     rd_data,
    input logic                 nmi_taken,
    input logic                 nmi_return,
    input logic                 gie,
    input logic [NUM_LINES-1:0] pend_lines,
    input logic                 pend_nmi,
    input logic                 pend_rst,
    input logic [NUM_LINES-1:0] qual_lines,
    input logic                 qual_nmi,
    input logic                 qual_rst
);
    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_data[31:16] == '0) && (rd_data[3:2] == 2'b00));

    a_r3_write_loads: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> rd_data[LINE_HI:LINE_LO] == $past(wr_data[LINE_HI:LINE_LO]));

    a_r3_hold: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(rd_data[LINE_HI:LINE_LO]));

    a_r4_no_sw_clear: assert property (@(posedge clk) disable iff (rst)
        (rd_data[NMI_BIT] && !nmi_taken) |=> rd_data[NMI_BIT]);

    a_r5_taken_clears: assert property (@(posedge clk) disable iff (rst)
        nmi_taken |=> !rd_data[NMI_BIT]);

    a_r6_return_sets: assert property (@(posedge clk) disable iff (rst)
        (nmi_return && !nmi_taken) |=> rd_data[NMI_BIT]);

    a_r7_rst_always: assert property (@(posedge clk) disable iff (rst)
        rd_data[RST_BIT] && (qual_rst == pend_rst));

    a_r9_gate_closed: assert property (@(posedge clk) disable iff (rst)
        (!rd_data[NMI_BIT] || !gie) |-> (qual_lines == '0));

    a_r8_nmi_gate: assert property (@(posedge clk) disable iff (rst)
        !rd_data[NMI_BIT] |-> !qual_nmi);
endmodule

bind irq_enable_reg irq_enable_reg_chk u_chk (.*);

// File: tb/sim_irq_enable_reg.sv
module sim_irq_enable_reg;
    localparam time CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [31:0] wr_data;
    logic [31:0] rd_data;
    logic        nmi_taken, nmi_return, gie;
    logic [11:0] pend_lines;
    logic        pend_nmi, pend_rst;
    logic [11:0] qual_lines;
    logic        qual_nmi, qual_rst;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_enable_reg u0 (.*);

    typedef struct packed {
        logic        we;
        logic [31:0] wd;
        logic        nt;
        logic        nr;
        logic        g;
        logic [11:0] pl;
        logic        pn;
        logic [31:0] exp_rd;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b1, 12'hFFF, 1'b1, 32'h0000_FFF3}, // R3 R4
        '{1'b1, 32'h0000_0000, 1'b0, 1'b0, 1'b1, 12'hFFF, 1'b1, 32'h0000_0003}, // R4 no clear
        '{1'b1, 32'h0000_A5A0, 1'b0, 1'b0, 1'b1, 12'h0F0, 1'b0, 32'h0000_A5A3}, // R3 pattern
        '{1'b1, 32'h0000_A5A2, 1'b1, 1'b0, 1'b1, 12'hFFF, 1'b1, 32'h0000_A5A1}, // R5 clr beats set
        '{1'b0, 32'h0000_0000, 1'b0, 1'b1, 1'b0, 12'hFFF, 1'b1, 32'h0000_A5A3}, // R6 return
        '{1'b0, 32'h0000_0000, 1'b1, 1'b1, 1'b1, 12'hA5A, 1'b1, 32'h0000_A5A1}, // R5 clr beats return
        '{1'b1, 32'hFFFF_000E, 1'b0, 1'b0, 1'b1, 12'hFFF, 1'b0, 32'h0000_0003}, // R2 reserved
        '{1'b1, 32'h0000_5A50, 1'b0, 1'b0, 1'b1, 12'h3C3, 1'b1, 32'h0000_5A53}  // R7 bit0
    };

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        wr_en = 0; wr_data = '0; nmi_taken = 0; nmi_return = 0;
    endtask

    task automatic check_quals(string tag, logic [31:0] exp_rd);
        logic        open;
        open = gie & exp_rd[1];
        check({tag, " R9 qual_lines"}, {20'd0, qual_lines},
              {20'd0, pend_lines & exp_rd[15:4] & {12{open}}});
        check({tag, " R8 qual_nmi"}, {31'd0, qual_nmi}, {31'd0, pend_nmi & exp_rd[1]});
        check({tag, " R7 qual_rst"}, {31'd0, qual_rst}, {31'd0, pend_rst});
    endtask

    initial begin
        rst = 1; idle(); gie = 0; pend_lines = '0; pend_nmi = 0; pend_rst = 0;
        repeat (2) @(posedge clk);
        @(negedge clk); rst = 0;
        #1 check("R1 reset value", rd_data, 32'h0000_0001);
        pend_lines = 12'hFFF; pend_nmi = 1; pend_rst = 1; gie = 1;
        #1 check_quals("R1 after reset", 32'h0000_0001);

        // table walk: drive at negedge, sample just after the next rising edge
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            wr_en = VECS[i].we; wr_data = VECS[i].wd;
            nmi_taken = VECS[i].nt; nmi_return = VECS[i].nr;
            gie = VECS[i].g; pend_lines = VECS[i].pl; pend_nmi = VECS[i].pn;
            pend_rst = i[0];
            @(posedge clk); #1;
            check($sformatf("R3/R4/R5/R6 vec %0d rd_data", i), rd_data, VECS[i].exp_rd);
            check_quals($sformatf("vec %0d", i), VECS[i].exp_rd);
        end

        // R10: the write is not visible before the edge
        @(negedge clk); idle(); wr_en = 1; wr_data = 32'h0000_0FF0;
        #1 check("R10 before edge", rd_data, 32'h0000_5A53);
        @(posedge clk); #1 check("R10 after edge", rd_data, 32'h0000_0FF3);

        // R9: gie low masks the lines while the NMI stays qualified
        @(negedge clk); idle(); gie = 0; pend_lines = 12'hFFF; pend_nmi = 1;
        #1 check("R9 gie low", {20'd0, qual_lines}, 32'd0);
        check("R8 nmi with gie low", {31'd0, qual_nmi}, 32'd1);

        // R5: an NMI taken alone clears the enable and closes every gate
        @(negedge clk); gie = 1; nmi_taken = 1;
        @(posedge clk); #1 check("R5 taken alone", rd_data, 32'h0000_0FF1);
        check("R9 closed after nmi", {20'd0, qual_lines}, 32'd0);
        check("R8 nmi blocked", {31'd0, qual_nmi}, 32'd0);

        // R1: reset from a non-zero state
        @(negedge clk); idle(); wr_en = 1; wr_data = 32'h0000_FFF2;
        @(negedge clk); idle(); rst = 1;
        @(negedge clk); rst = 0;
        #1 check("R1 reset from loaded state", rd_data, 32'h0000_0001);

        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (2000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule